// File: doc/BRIEF.md
# Audio Packet Block-Count Sequencer

This block runs once per 8 kHz isochronous bus cycle. For each cycle it decides how many audio data blocks (sample frames) the next outgoing packet carries, so that the long-term block rate matches the selected sample rate exactly. It also keeps the 8-bit running data-block counter that goes into the packet header. A stream begins with a `start` pulse. That pulse captures the rate code, the blocking/non-blocking choice and the counter convention, and clears the internal phase and counter. After that, every `cyc_tick` strobe produces one count and one header counter value.

In blocking mode, a packet either carries a fixed group of blocks or is empty. A time stamp of all ones marks an empty packet. In non-blocking mode, the rates that divide evenly by 8000 give a constant count. The 44.1 kHz family uses a phase counter that places the rounded-up counts as early as possible in a repeating pattern. Over one pattern period this yields exactly 441 blocks.

Top module: `blk_sequencer`

## Requirements
- R1: While reset is held and right after it, `blk_count` and `dbc_out` read 0.
- R2: In blocking mode, a tick with `stamp` = 16'hFFFF yields 0 blocks. Any other stamp yields 8 blocks for rate codes 0..2, 16 for codes 3..4, 32 for codes 5..6, and 0 for code 7. Rate codes: 0=32k, 1=44.1k, 2=48k, 3=88.2k, 4=96k, 5=176.4k, 6=192k.
- R3: In non-blocking mode, rate codes 0, 2, 4 and 6 yield a constant 4, 6, 12 and 24 blocks per tick, and code 7 yields 0.
- R4: In non-blocking mode at code 1, packet k of a period of 80 carries ceil((k+1)*441/80) - ceil(k*441/80) blocks, giving the pattern 6 6 5 6 5 ... and a sum of 441 per period.
- R5: In non-blocking mode, code 3 uses the same rule with a period of 40 (12 then 11s), and code 5 uses a period of 20 (23 then 22s).
- R6: `start` clears the phase and the counter. `rate_sel`, `blocking_mode` and `dbc_after_mode` take effect only at `start`; changing them later has no effect.
- R7: With `dbc_after_mode` = 0, `dbc_out` is the counter value before this packet's blocks are added. The counter advances by the block count modulo 256.
- R8: With `dbc_after_mode` = 1, `dbc_out` is the counter value after this packet's blocks are added, modulo 256.
- R9: The outputs change only on the clock edge that samples a `cyc_tick` or `start`, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Stream start: captures the configuration, clears phase and counter |
| rate_sel | input | 3 | Sample-rate code |
| blocking_mode | input | 1 | 1 = blocking mode, 0 = non-blocking mode |
| dbc_after_mode | input | 1 | 1 = header counter includes the current packet |
| cyc_tick | input | 1 | One-clock strobe per bus cycle |
| stamp | input | 16 | Time stamp for the cycle; all ones means no data |
| blk_count | output | 6 | Blocks in this cycle's packet |
| dbc_out | output | 8 | Header data-block counter |

## Verification
Every result is due one clock after the edge that samples the strobe. The bench raises `cyc_tick` on a falling edge and lowers it on the next falling edge, then compares the outputs there, a half period after the capturing edge. One check samples the outputs before the capturing rising edge, which shows they have not yet moved. Another check samples them after several idle clocks, which shows they hold. The expected counts come from the ceiling-difference formula and a running modulo-256 sum kept in the bench.

// File: rtl/blk_sequencer.sv
module blk_sequencer #(
  parameter int CNT_W = 6,
  parameter int DBC_W = 8,
  parameter int PH_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       rate_sel,
  input  logic             blocking_mode,
  input  logic             dbc_after_mode,
  input  logic             cyc_tick,
  input  logic [15:0]      stamp,
  output logic [CNT_W-1:0] blk_count,
  output logic [DBC_W-1:0] dbc_out
);
  localparam logic [15:0] NO_INFO = 16'hFFFF;

  logic [2:0]       rate_q;
  logic             blk_q, end_q;
  logic [PH_W-1:0]  phase, ph_last;
  logic [DBC_W-1:0] ctr, ctr_next;
  logic [CNT_W-1:0] nb_cnt, grp_cnt, cnt;
  logic             ph_zero, fam44;

  assign ph_zero = (phase == '0);
  assign fam44   = (rate_q == 3'd1) || (rate_q == 3'd3) || (rate_q == 3'd5);

  always_comb begin
    nb_cnt  = '0;
    ph_last = '0;
    case (rate_q)
      3'd0: nb_cnt = CNT_W'(4);
      3'd1: begin
        nb_cnt  = CNT_W'(5) + CNT_W'(phase[0] ^ (ph_zero || phase >= PH_W'(40)));
        ph_last = PH_W'(79);
      end
      3'd2: nb_cnt = CNT_W'(6);
      3'd3: begin
        nb_cnt  = CNT_W'(11) + CNT_W'(ph_zero);
        ph_last = PH_W'(39);
      end
      3'd4: nb_cnt = CNT_W'(12);
      3'd5: begin
        nb_cnt  = CNT_W'(22) + CNT_W'(ph_zero);
        ph_last = PH_W'(19);
      end
      3'd6: nb_cnt = CNT_W'(24);
      default: nb_cnt = '0;
    endcase
  end

  always_comb begin
    case (rate_q)
      3'd0, 3'd1, 3'd2: grp_cnt = CNT_W'(8);
      3'd3, 3'd4:       grp_cnt = CNT_W'(16);
      3'd5, 3'd6:       grp_cnt = CNT_W'(32);
      default:          grp_cnt = '0;
    endcase
  end

  assign cnt      = blk_q ? ((stamp == NO_INFO) ? '0 : grp_cnt) : nb_cnt;
  assign ctr_next = ctr + DBC_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q    <= '0;
      blk_q     <= 1'b0;
      end_q     <= 1'b0;
      phase     <= '0;
      ctr       <= '0;
      blk_count <= '0;
      dbc_out   <= '0;
    end else if (start) begin
      rate_q    <= rate_sel;
      blk_q     <= blocking_mode;
      end_q     <= dbc_after_mode;
      phase     <= '0;
      ctr       <= '0;
      blk_count <= '0;
      dbc_out   <= '0;
    end else if (cyc_tick) begin
      blk_count <= cnt;
      ctr       <= ctr_next;
      dbc_out   <= end_q ? ctr_next : ctr;
      if (!blk_q && fam44)
        phase <= (phase == ph_last) ? '0 : phase + PH_W'(1);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_tick && !start) |=> ($stable(blk_count) && $stable(dbc_out)));

  assert_empty_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && cyc_tick && !start && stamp == NO_INFO) |=> (blk_count == '0));

  assert_ctr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !start) |=> (ctr == DBC_W'($past(ctr) + DBC_W'(blk_count))));

  assert_hdr_before_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_q && cyc_tick && !start) |=> (dbc_out == $past(ctr)));

  assert_hdr_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && cyc_tick && !start) |=> (dbc_out == ctr));

  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 3'd1) |-> (phase < PH_W'(80)));

  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ctr == '0 && phase == '0 && blk_count == '0));
endmodule

// File: tb/test_blk_sequencer.sv
`timescale 1ns/1ps
module test_blk_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic blocking_mode = 1'b0;
  logic dbc_after_mode = 1'b0;
  logic cyc_tick = 1'b0;
  logic [15:0] stamp = 16'h0;
  logic [5:0] blk_count;
  logic [7:0] dbc_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  blk_sequencer i_blk_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
    .blocking_mode(blocking_mode), .dbc_after_mode(dbc_after_mode),
    .cyc_tick(cyc_tick), .stamp(stamp), .blk_count(blk_count), .dbc_out(dbc_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int period_of(input int r);
    return (r == 1) ? 80 : (r == 3) ? 40 : (r == 5) ? 20 : 0;
  endfunction

  function automatic int exp_cnt(input int r, input bit blk, input int k, input logic [15:0] s);
    int p;
    if (blk) begin
      if (s == 16'hFFFF || r == 7) return 0;
      return (r <= 2) ? 8 : (r <= 4) ? 16 : 32;
    end
    case (r)
      0: return 4;
      2: return 6;
      4: return 12;
      6: return 24;
      1, 3, 5: begin
        p = period_of(r);
        return cdiv(((k % p) + 1) * 441, p) - cdiv((k % p) * 441, p);
      end
      default: return 0;
    endcase
  endfunction

  task automatic do_start(input int r, input bit blk, input bit endm);
    @(negedge clk);
    rate_sel = 3'(r); blocking_mode = blk; dbc_after_mode = endm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic tick(input logic [15:0] s);
    @(negedge clk);
    cyc_tick = 1'b1; stamp = s;
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic run_seq(input int r, input bit blk, input bit endm, input int n, input string req);
    int ctr = 0;
    int sum = 0;
    int e;
    int hdr;
    logic [15:0] s;
    do_start(r, blk, endm);
    chk("R6", int'(blk_count), 0);
    chk("R6", int'(dbc_out), 0);
    for (int k = 0; k < n; k++) begin
      s = (k % 3 == 2) ? 16'hFFFF : 16'(k * 37);
      tick(s);
      e = exp_cnt(r, blk, k, s);
      hdr = endm ? ((ctr + e) % 256) : ctr;
      ctr = (ctr + e) % 256;
      sum += e;
      chk(req, int'(blk_count), e);
      chk(endm ? "R8" : "R7", int'(dbc_out), hdr);
      if (!blk && period_of(r) != 0 && k + 1 == period_of(r))
        chk(req, sum, 441);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(blk_count), 0);
    chk("R1", int'(dbc_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(blk_count), 0);
    chk("R1", int'(dbc_out), 0);

    for (int r = 0; r < 8; r++) begin
      run_seq(r, 1'b0, 1'b0, 170, (r == 1) ? "R4" : (r == 3 || r == 5) ? "R5" : "R3");
      run_seq(r, 1'b1, 1'b0, 40, "R2");
      run_seq(r, 1'b0, 1'b1, 90, (r == 1) ? "R4" : (r == 3 || r == 5) ? "R5" : "R3");
      run_seq(r, 1'b1, 1'b1, 40, "R2");
    end

    // R6: restart mid-pattern resets phase; later config changes ignored
    do_start(1, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) tick(16'h0);
    do_start(1, 1'b0, 1'b0);
    rate_sel = 3'd6; blocking_mode = 1'b1; dbc_after_mode = 1'b1;
    tick(16'hFFFF);
    chk("R6", int'(blk_count), 6);
    chk("R6", int'(dbc_out), 0);
    tick(16'h0);
    chk("R6", int'(blk_count), 6);
    chk("R6", int'(dbc_out), 6);

    // R9: not moved before the capturing edge, held when idle
    @(negedge clk);
    cyc_tick = 1'b1;
    #2;
    chk("R9", int'(dbc_out), 6);
    @(negedge clk);
    cyc_tick = 1'b0;
    chk("R9", int'(blk_count), 5);
    chk("R9", int'(dbc_out), 12);
    repeat (5) @(negedge clk);
    chk("R9", int'(blk_count), 5);
    chk("R9", int'(dbc_out), 12);

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", int'(blk_count), 0);
    chk("R1", int'(dbc_out), 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule